// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Byte-Lane Masking

This block models the device side of a 16-bit synchronous DRAM at the level of column accesses. It decodes a small command bus with mode-load, read and write commands against an internal word array. It returns read bursts after a programmable CAS latency and takes in write bursts one beat per cycle. Two byte-lane mask inputs gate what is stored on each write beat and blank the output drivers on read beats.

A mode-load command sets the burst length, the burst address order and the CAS latency. It also sets a write mode that keeps reads at full burst length but turns every write into a single-word store. The block fits a memory-controller testbed that needs a cycle-accurate, synthesizable stand-in for the memory. The data bus is split into separate input, output and per-lane output-enable signals.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, both `dq_oe` bits are 0 and the mode is burst length 4, sequential order, CAS latency 2, burst writes.
- R2: A mode-load command (`cmd`=01) takes `addr[2:0]` as burst length (000=1, 001=2, 010=4, 011=8, others 1), `addr[3]` as order (0 sequential, 1 interleaved), `addr[6:4]` as CAS latency (011 gives 3, any other code gives 2) and `addr[9]` as write mode (1 single-word writes). `cmd` codes are 00 idle, 01 mode load, 10 read, 11 write.
- R3: Beat k of a read sampled at clock edge n is on `dq_out` with `dq_oe`=11 in the cycle after edge n+k+CL-1. `dq_oe` returns to 00 once the burst is over.
- R4: In sequential order, beat k addresses column (col & ~(BL-1)) | ((col+k) mod BL), so the burst wraps inside its aligned block.
- R5: In interleaved order, beat k addresses column col XOR k.
- R6: A write stores beat 0 from `dq_in` at the edge that samples the command, at word {`ba`,`col`}. It stores beat k at the edge k cycles later.
- R7: A high `dqm_hi` on a write beat keeps `dq_in[15:8]` out of the array on that same beat, and a high `dqm_lo` does the same for `dq_in[7:0]`. The two lanes act independently, and storing resumes on the first beat with the mask low.
- R8: Masked write beats still advance the burst address, so later unmasked beats land at their normal columns.
- R9: With single-word write mode set, a write stores only beat 0 at the addressed column, and reads still return the full programmed burst with unchanged latency and masking.
- R10: During reads, a mask input that is high at edge m forces its lane of `dq_oe` low in the cycle after edge m+1. This is a read mask latency of 2, per lane.
- R11: A read or write command that arrives during a burst ends that burst and starts the new one. Read beats already issued still appear at the CAS latency.
- R12: Burst lengths 1, 2 and 8 stop after exactly that many beats, wrapping inside their block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 00 idle, 01 mode load, 10 read, 11 write |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Column address for read and write; mode fields for mode load |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Output enable per lane, bit 1 upper byte, bit 0 lower byte |
| dqm_hi | input | 1 | Upper byte mask |
| dqm_lo | input | 1 | Lower byte mask |

## Verification
The bench uses the default parameters: two banks of 512 columns, a 10-bit address and a 1024-word array. It fills every word and then checks each read beat against its own reference copy. Nine column bits reach across many aligned blocks, so the runs can place sequential and interleaved wraps at block edges and start bursts at unaligned columns. The spare address bit 9 lets single-word write mode be toggled without disturbing any column field. Both banks are used, so a bank-select fault shows up as a data mismatch.

// File: rtl/sdram_eng_pkg.sv
package sdram_eng_pkg;

  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int LOW_W  = 3;   // column bits touched by bursts up to 8

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_MRS   = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } cmd_e;

  typedef struct packed {
    logic [3:0] len;     // burst length in words
    logic       il;      // 1: interleaved order
    logic       cl3;     // 1: CAS latency 3, else 2
    logic       single;  // 1: single-word writes
  } mode_t;

  function automatic logic [3:0] decode_len(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic decode_cl3(input logic [2:0] code);
    return code == 3'b011;
  endfunction

  // Low column bits of beat 'beat' inside the aligned block of 'len'.
  function automatic logic [LOW_W-1:0] burst_low(input logic [LOW_W-1:0] base,
                                                 input logic [LOW_W-1:0] beat,
                                                 input logic [3:0]       len,
                                                 input logic             il);
    logic [LOW_W-1:0] msk;
    logic [LOW_W-1:0] off;
    msk = LOW_W'(len - 4'd1);
    off = il ? (base ^ beat) : (base + beat);
    return (base & ~msk) | (off & msk);
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] bl_code,
  input  logic       order_bit,
  input  logic [2:0] cl_code,
  input  logic       wmode_bit,
  output mode_t      mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode.len    <= 4'd4;
      mode.il     <= 1'b0;
      mode.cl3    <= 1'b0;
      mode.single <= 1'b0;
    end else if (load) begin
      mode.len    <= decode_len(bl_code);
      mode.il     <= order_bit;
      mode.cl3    <= decode_cl3(cl_code);
      mode.single <= wmode_bit;
    end
  end

endmodule

// File: rtl/sdram_burst_ctrl.sv
module sdram_burst_ctrl
  import sdram_eng_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int COL_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cmd,
  input  logic [BANK_W-1:0]       ba,
  input  logic [COL_W-1:0]        col,
  input  mode_t                   mode,
  output logic                    acc_valid,
  output logic                    acc_write,
  output logic [BANK_W+COL_W-1:0] acc_addr
);

  cmd_e c;
  assign c = cmd_e'(cmd);

  // Named command events, used by the assertions below.
  logic cmd_rd, cmd_wr, cmd_mrs, start;
  assign cmd_rd  = (c == CMD_READ);
  assign cmd_wr  = (c == CMD_WRITE);
  assign cmd_mrs = (c == CMD_MRS);
  assign start   = cmd_rd | cmd_wr;

  logic [3:0] len_eff;
  assign len_eff = (cmd_wr && mode.single) ? 4'd1 : mode.len;

  logic              act_q, wr_q, il_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  base_q;
  logic [LOW_W-1:0]  beat_q;
  logic [3:0]        len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      il_q   <= 1'b0;
      bank_q <= '0;
      base_q <= '0;
      beat_q <= '0;
      len_q  <= 4'd1;
    end else if (start) begin
      act_q  <= (len_eff != 4'd1);
      wr_q   <= cmd_wr;
      il_q   <= mode.il;
      bank_q <= ba;
      base_q <= col;
      beat_q <= LOW_W'(1);
      len_q  <= len_eff;
    end else if (cmd_mrs) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      if ({1'b0, beat_q} == len_q - 4'd1) act_q <= 1'b0;
      else                                beat_q <= beat_q + LOW_W'(1);
    end
  end

  // A fresh command takes the access slot in its own cycle.
  always_comb begin
    if (start) begin
      acc_valid = 1'b1;
      acc_write = cmd_wr;
      acc_addr  = {ba, col};
    end else begin
      acc_valid = act_q;
      acc_write = wr_q;
      acc_addr  = {bank_q, base_q[COL_W-1:LOW_W],
                   burst_low(base_q[LOW_W-1:0], beat_q, len_q, il_q)};
    end
  end

  assert_beat_in_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ({1'b0, beat_q} < len_q));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && mode.single) |=> !act_q);

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!act_q || beat_q == LOW_W'(1)));

  assert_mrs_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrs |=> !act_q);

endmodule

// File: rtl/sdram_array.sv
module sdram_array
  import sdram_eng_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (be[ln]) mem[addr][ln*LANE_W +: LANE_W] <= wdata[ln*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
  import sdram_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              cl3,
  input  logic              dqm_hi,
  input  logic              dqm_lo,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe
);

  localparam int CL_LO  = 2;
  localparam int CL_HI  = 3;
  localparam int MASK_D = 2;

  logic [CL_HI:1]    v_q;
  logic [DATA_W-1:0] d_q [1:CL_HI];
  logic [LANES-1:0]  m_q [1:MASK_D];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int s = 1; s <= MASK_D; s++) m_q[s] <= '0;
    end else begin
      v_q    <= {v_q[CL_HI-1:1], rd_issue};
      m_q[1] <= {dqm_hi, dqm_lo};
      for (int s = 2; s <= MASK_D; s++) m_q[s] <= m_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[1] <= rd_word;
    for (int s = 2; s <= CL_HI; s++) d_q[s] <= d_q[s-1];
  end

  logic out_valid;
  assign out_valid = cl3 ? v_q[CL_HI] : v_q[CL_LO];
  assign dq_out    = cl3 ? d_q[CL_HI] : d_q[CL_LO];
  assign dq_oe     = {LANES{out_valid}} & ~m_q[MASK_D];

  assert_cas2_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_issue, 2) && !cl3 && $past(!cl3)) |-> out_valid);

  assert_cas3_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_issue, 3) && cl3 && $past(cl3)) |-> out_valid);

  assert_rmask_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm_hi, 2) |-> !dq_oe[1]);

  assert_rmask_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm_lo, 2) |-> !dq_oe[0]);

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdram_eng_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  input  logic              dqm_hi,
  input  logic              dqm_lo
);

  localparam int AW = BANK_W + COL_W;

  mode_t          mode;
  logic           acc_valid, acc_write;
  logic [AW-1:0]  acc_addr;
  logic [15:0]    rd_word;

  // Internal events, named for the checks.
  logic       wr_fire, rd_fire;
  logic [1:0] wr_be;
  assign wr_fire = acc_valid & acc_write;
  assign rd_fire = acc_valid & ~acc_write;
  assign wr_be   = {~dqm_hi, ~dqm_lo};

  sdram_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_e'(cmd) == CMD_MRS),
    .bl_code   (addr[2:0]),
    .order_bit (addr[3]),
    .cl_code   (addr[6:4]),
    .wmode_bit (addr[9]),
    .mode      (mode)
  );

  sdram_burst_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ba        (ba),
    .col       (addr[COL_W-1:0]),
    .mode      (mode),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr)
  );

  sdram_array #(.AW(AW)) u_array (
    .clk   (clk),
    .we    (wr_fire),
    .be    (wr_be),
    .addr  (acc_addr),
    .wdata (dq_in),
    .rdata (rd_word)
  );

  sdram_read_pipe u_rpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (rd_fire),
    .rd_word  (rd_word),
    .cl3      (mode.cl3),
    .dqm_hi   (dqm_hi),
    .dqm_lo   (dqm_lo),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  assert_no_oe_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> dq_oe == 2'b00);

endmodule

// File: tb/tb_sdram_burst_engine.sv
module tb_sdram_burst_engine;
  import sdram_eng_pkg::*;

  localparam int NCOL = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [0:0]  ba = '0;
  logic [9:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        dqm_hi = 1'b0, dqm_lo = 1'b0;

  sdram_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .dqm_hi(dqm_hi), .dqm_lo(dqm_lo)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] ref_mem [2*NCOL];
  int b_len = 4, b_il = 0, b_cl = 2, b_sw = 0;

  function automatic logic [15:0] pat(input int seed, input int k);
    return 16'((seed * 16'h0137) ^ (k * 16'h1021) ^ 16'h5A3C);
  endfunction

  function automatic int baddr(input int bk, input int col, input int k);
    int blk = col - (col % b_len);
    int lo  = b_il ? ((col % b_len) ^ k) : ((col + k) % b_len);
    return bk * NCOL + blk + lo;
  endfunction

  task automatic chk(input string tag, input int k, input logic [15:0] ed, input logic [1:0] eo);
    logic [15:0] lm = {{8{eo[1]}}, {8{eo[0]}}};
    total++;
    if (dq_oe !== eo || (dq_out & lm) !== (ed & lm)) begin
      bad++;
      $display("FAIL %s beat %0d: got data %h oe %b, expected data %h oe %b",
               tag, k, dq_out & lm, dq_oe, ed & lm, eo);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmd = CMD_NOP; dqm_hi = 0; dqm_lo = 0;
  endtask

  task automatic mrs(input int len, input int il, input int cl, input int sw);
    logic [2:0] bc = (len == 8) ? 3'b011 : (len == 4) ? 3'b010 : (len == 2) ? 3'b001 : 3'b000;
    @(negedge clk);
    cmd = CMD_MRS; dqm_hi = 0; dqm_lo = 0;
    addr = {sw[0], 2'b00, (cl == 3) ? 3'b011 : 3'b010, il[0], bc};
    b_len = len; b_il = il; b_cl = cl; b_sw = sw;
  endtask

  task automatic wr_burst(input int bk, input int col, input int nb,
                          input logic [7:0] mh, input logic [7:0] ml, input int seed);
    int eff = b_sw ? 1 : b_len;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      cmd = (k == 0) ? CMD_WRITE : CMD_NOP;
      ba = bk[0]; addr = 10'(col);
      dq_in = pat(seed, k); dqm_hi = mh[k]; dqm_lo = ml[k];
      if (k < eff) begin
        int a = baddr(bk, col, k);
        if (!mh[k]) ref_mem[a][15:8] = dq_in[15:8];
        if (!ml[k]) ref_mem[a][7:0]  = dq_in[7:0];
      end
    end
  endtask

  task automatic rd_check(input int bk, input int col, input logic [7:0] mh,
                          input logic [7:0] ml, input string tag);
    for (int j = 0; j <= b_cl + b_len; j++) begin
      int m;
      @(negedge clk);
      if (j >= b_cl) begin
        int k = j - b_cl;
        if (k < b_len) chk(tag, k, ref_mem[baddr(bk, col, k)], {~mh[k], ~ml[k]});
        else           chk({tag, " end"}, k, 16'h0, 2'b00);
      end
      cmd = (j == 0) ? CMD_READ : CMD_NOP;
      if (j == 0) begin ba = bk[0]; addr = 10'(col); end
      m = j + 2 - b_cl;
      dqm_hi = (m >= 0 && m < b_len) ? mh[m] : 1'b0;
      dqm_lo = (m >= 0 && m < b_len) ? ml[m] : 1'b0;
    end
    idle();
  endtask

  // Scenarios
  task automatic t_reset();
    @(negedge clk);
    total++;
    if (dq_oe !== 2'b00) begin bad++; $display("FAIL R1 oe after reset: got %b expected 00", dq_oe); end
    wr_burst(1, 16'h012, 4, 8'h0, 8'h0, 7);   // defaults: BL4 sequential CL2
    rd_check(1, 16'h012, 8'h0, 8'h0, "R1 default mode");
  endtask

  task automatic t_fill();
    mrs(8, 0, 2, 0);
    for (int bk = 0; bk < 2; bk++)
      for (int c = 0; c < NCOL; c += 8) wr_burst(bk, c, 8, 8'h0, 8'h0, bk * NCOL + c);
    idle();
  endtask

  task automatic t_seq_wrap();
    mrs(4, 0, 3, 0);
    rd_check(0, 16'h005, 8'h0, 8'h0, "R4 R2 R3 seq wrap CL3");
    mrs(8, 0, 2, 0);
    rd_check(1, 16'h1FE, 8'h0, 8'h0, "R4 R3 seq wrap BL8");
  endtask

  task automatic t_interleave();
    mrs(8, 1, 2, 0);
    rd_check(1, 16'h013, 8'h0, 8'h0, "R5 interleaved read");
    wr_burst(0, 16'h02E, 8, 8'h0, 8'h0, 901);
    rd_check(0, 16'h02E, 8'h0, 8'h0, "R5 R6 interleaved write");
  endtask

  task automatic t_wmask();
    mrs(4, 0, 2, 0);
    wr_burst(0, 16'h021, 4, 8'b0110, 8'b1100, 333);
    rd_check(0, 16'h021, 8'h0, 8'h0, "R7 R8 R6 masked write");
    wr_burst(1, 16'h0A4, 4, 8'b0011, 8'b0011, 444);
    rd_check(1, 16'h0A4, 8'h0, 8'h0, "R7 R8 both lanes masked");
  endtask

  task automatic t_rmask();
    mrs(4, 0, 3, 0);
    rd_check(0, 16'h100, 8'b0101, 8'b1100, "R10 read mask CL3");
    mrs(4, 0, 2, 0);
    rd_check(1, 16'h0C3, 8'b1010, 8'b0001, "R10 read mask CL2");
  endtask

  task automatic t_single();
    mrs(4, 0, 2, 1);
    wr_burst(1, 16'h031, 4, 8'h0, 8'h0, 555);
    rd_check(1, 16'h030, 8'h0, 8'h0, "R9 single write");
    wr_burst(0, 16'h142, 4, 8'h0, 8'b0001, 556);
    rd_check(0, 16'h140, 8'b0100, 8'h0, "R9 single write with mask");
    mrs(4, 0, 2, 0);
  endtask

  task automatic t_interrupt();
    int ca = 16'h040, cb = 16'h085;
    mrs(4, 0, 3, 0);
    for (int j = 0; j <= b_cl + 2 + b_len; j++) begin
      @(negedge clk);
      if (j >= b_cl) begin
        int x = j - b_cl;
        if (x < 2)               chk("R11 first read", x, ref_mem[baddr(0, ca, x)], 2'b11);
        else if (x < 2 + b_len)  chk("R11 second read", x - 2, ref_mem[baddr(1, cb, x - 2)], 2'b11);
        else                     chk("R11 end", x, 16'h0, 2'b00);
      end
      cmd = (j == 0 || j == 2) ? CMD_READ : CMD_NOP;
      if (j == 0) begin ba = 0; addr = 10'(ca); end
      if (j == 2) begin ba = 1; addr = 10'(cb); end
    end
    idle();
    mrs(4, 0, 2, 0);
    wr_burst(0, 16'h060, 2, 8'h0, 8'h0, 777);   // cut after two beats
    wr_burst(0, 16'h068, 4, 8'h0, 8'h0, 778);
    rd_check(0, 16'h060, 8'h0, 8'h0, "R11 cut write");
    rd_check(0, 16'h068, 8'h0, 8'h0, "R11 second write");
  endtask

  task automatic t_short();
    mrs(1, 0, 2, 0);
    wr_burst(1, 16'h155, 1, 8'h0, 8'h0, 881);
    rd_check(1, 16'h155, 8'h0, 8'h0, "R12 BL1");
    mrs(2, 0, 3, 0);
    wr_burst(0, 16'h007, 2, 8'h0, 8'h0, 882);
    rd_check(0, 16'h007, 8'h0, 8'h0, "R12 BL2 wrap");
    mrs(2, 1, 2, 0);
    rd_check(1, 16'h1E1, 8'h0, 8'h0, "R12 R5 BL2 interleaved");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1..all: got running, expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_seq_wrap();
    t_interleave();
    t_wmask();
    t_rmask();
    t_single();
    t_interrupt();
    t_short();
    repeat (4) idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule